// File: doc/BRIEF.md
# Radio Transceiver State Controller

This block is the control state machine of a packet radio transceiver. It comes out of reset in a power-on state. Commands written to a command field move it into the off state, into the synthesizer-running state, and into receive. On the way it switches the voltage regulator on first, and the frequency synthesizer second. It waits for the settle and lock indications, and each wait is bounded by a programmable cycle limit. The analog parts and the demodulator are outside the block. They appear only as enable outputs and as indication and strobe inputs.

Receive has two substates. Listen is the one reported for a receive command. Busy is entered by the hardware itself when a sync header is detected, and it is left at end of frame. A receive command is accepted before the synthesizer has locked. The status field then already shows listen, but frame reception stays gated off until lock. Events set sticky interrupt flags, and reading the flags clears them. A masked OR of the flags drives one interrupt line.

Top module: `rtrx_ctrl`

## Requirements
- R1: While reset is held, and on leaving it: status_code is 0x00 (power-on), all enables are low, crc_valid is 0, irq_flags is 0 and irq is 0.
- R2: In power-on, only the off command (cmd_code 0x08) has an effect. It moves status_code to 0x08 and sets flag bit 3 (awake). Other commands in power-on change nothing.
- R3: An on command (0x09) in the off state raises vreg_en one cycle later, with status_code 0x1F and synth_en low. synth_en rises only in the cycle after reg_ready is seen.
- R4: While waiting for lock, a high pll_locked sets flag bit 0 (lock). With no pending receive command it moves status_code to 0x09. After lock, frame_rx_en follows rx_en.
- R5: A receive command (0x06) during the lock wait moves status_code to 0x06 and raises rx_en one cycle later. frame_rx_en stays low until lock, and shr_seen before lock is ignored.
- R6: In listen with the synthesizer locked, shr_seen moves status_code to 0x01 (busy) without any command.
- R7: In busy, phr_valid sets flag bit 1 (rx start) and the status stays 0x01.
- R8: In busy, frame_end returns status_code to 0x06 and sets flag bit 2 (end). In that same cycle crc_valid takes the value of fcs_ok. crc_valid changes at no other time.
- R9: Listen is left only by a command: 0x09 gives status 0x09 with rx_en low, and 0x08 gives status 0x08 with every enable low. Commands during busy are ignored.
- R10: If reg_ready does not arrive within settle_cycles cycles, the block falls back to the off state. The same applies if pll_locked does not arrive within lock_cycles cycles. In that case status_code is 0x08, the enables are low and flag bit 4 (timeout) is set.
- R11: A flag stays set until a cycle with irq_rd high clears all flags. An event in the read cycle still leaves its flag set. irq is high exactly when a flag set in irq_flags has its irq_mask bit set (mask held steady for a cycle).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wr | input | 1 | Command write strobe |
| cmd_code | input | 5 | Command: 0x08 off, 0x09 synth on, 0x06 receive |
| settle_cycles | input | CNT_W | Regulator settle limit in cycles |
| lock_cycles | input | CNT_W | Synthesizer lock limit in cycles |
| reg_ready | input | 1 | Regulator settled indication |
| pll_locked | input | 1 | Synthesizer lock indication |
| shr_seen | input | 1 | Sync header detected strobe |
| phr_valid | input | 1 | Valid PHY header strobe |
| frame_end | input | 1 | End of frame strobe |
| fcs_ok | input | 1 | Frame check result, valid with frame_end |
| irq_rd | input | 1 | Flag register read, clears flags |
| irq_mask | input | 5 | Per-flag interrupt enable |
| vreg_en | output | 1 | Voltage regulator enable |
| synth_en | output | 1 | Frequency synthesizer enable |
| rx_en | output | 1 | Receiver enable |
| frame_rx_en | output | 1 | Frame reception allowed (receiver on and locked) |
| status_code | output | 5 | Current state code |
| crc_valid | output | 1 | Frame check result of the last frame |
| irq_flags | output | 5 | Sticky flags: 0 lock, 1 rx start, 2 end, 3 awake, 4 timeout |
| irq | output | 1 | Masked interrupt line |

## Verification
The assertions rely on a demodulator that sends header and end strobes only in the states where they are meaningful. They also rely on the settle and lock limits staying constant while a wait is in progress. The stimulus respects both. Random settle and lock delays are always drawn below the programmed limits, except in the directed timeout cases. Frames are sent only after lock, and strobes before lock are used only to show that they are ignored. Commands arrive as single-cycle writes, and lock indication is held as a level from lock until the off command.

// File: rtl/rtrx_pkg.sv
package rtrx_pkg;
  localparam int CODE_W = 5;
  localparam int IRQ_N  = 5;

  localparam int IRQ_LOCK  = 0;
  localparam int IRQ_RXSTA = 1;
  localparam int IRQ_END   = 2;
  localparam int IRQ_AWAKE = 3;
  localparam int IRQ_TMO   = 4;

  localparam logic [CODE_W-1:0] CODE_PON   = 5'h00;
  localparam logic [CODE_W-1:0] CODE_OFF   = 5'h08;
  localparam logic [CODE_W-1:0] CODE_SYN   = 5'h09;
  localparam logic [CODE_W-1:0] CODE_RX    = 5'h06;
  localparam logic [CODE_W-1:0] CODE_BUSY  = 5'h01;
  localparam logic [CODE_W-1:0] CODE_TRANS = 5'h1F;

  typedef enum logic [2:0] {
    S_PON, S_OFF, S_REGW, S_PLLW, S_PLLON, S_LISTEN, S_BUSY
  } rtrx_state_e;

  function automatic logic [CODE_W-1:0] code_of(rtrx_state_e s);
    case (s)
      S_OFF:    return CODE_OFF;
      S_REGW:   return CODE_TRANS;
      S_PLLW:   return CODE_TRANS;
      S_PLLON:  return CODE_SYN;
      S_LISTEN: return CODE_RX;
      S_BUSY:   return CODE_BUSY;
      default:  return CODE_PON;
    endcase
  endfunction
endpackage

// File: rtl/rtrx_wait_timer.sv
module rtrx_wait_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             run,
  input  logic [CNT_W-1:0] limit,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                      cnt_q <= '0;
    else if (start)               cnt_q <= '0;
    else if (run && cnt_q != limit) cnt_q <= cnt_q + 1'b1;
  end

  assign expired = run && !start && (cnt_q == limit);

  // counter never walks past a steady limit during a wait
  p_cnt_bounded_r10: assert property (@(posedge clk) disable iff (rst)
    (run && !start && cnt_q <= limit) |=> ($stable(limit) -> cnt_q <= limit));
endmodule

// File: rtl/rtrx_irq_bank.sv
module rtrx_irq_bank #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_ev,
  input  logic         rd_clr,
  input  logic [N-1:0] mask,
  output logic [N-1:0] flags,
  output logic         irq
);
  logic [N-1:0] flags_q, flags_d;
  logic         irq_q;

  always_comb flags_d = (rd_clr ? '0 : flags_q) | set_ev;

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      flags_q <= flags_d;
      irq_q   <= |(flags_d & mask);
    end
  end

  assign flags = flags_q;
  assign irq   = irq_q;

  // without a read, no set flag drops
  p_sticky_r11: assert property (@(posedge clk) disable iff (rst)
    !rd_clr |=> ((flags_q & $past(flags_q)) == $past(flags_q)));
  // an event in a read cycle survives the clear
  p_event_wins_r11: assert property (@(posedge clk) disable iff (rst)
    (rd_clr && |set_ev) |=> ((flags_q & $past(set_ev)) == $past(set_ev)));
endmodule

// File: rtl/rtrx_ctrl.sv
module rtrx_ctrl
  import rtrx_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_wr,
  input  logic [4:0]        cmd_code,
  input  logic [CNT_W-1:0]  settle_cycles,
  input  logic [CNT_W-1:0]  lock_cycles,
  input  logic              reg_ready,
  input  logic              pll_locked,
  input  logic              shr_seen,
  input  logic              phr_valid,
  input  logic              frame_end,
  input  logic              fcs_ok,
  input  logic              irq_rd,
  input  logic [4:0]        irq_mask,
  output logic              vreg_en,
  output logic              synth_en,
  output logic              rx_en,
  output logic              frame_rx_en,
  output logic [4:0]        status_code,
  output logic              crc_valid,
  output logic [4:0]        irq_flags,
  output logic              irq
);
  rtrx_state_e st_q, st_d;
  logic locked_q, locked_d;
  logic crc_q, crc_d;
  logic [IRQ_N-1:0] ev;
  logic tmr_start, tmr_run, tmo;
  logic [CNT_W-1:0] tmr_limit;
  logic c_off, c_syn, c_rx;
  logic vreg_q, synth_q, rx_q, frx_q;
  logic [CODE_W-1:0] code_q;

  assign c_off = cmd_wr && (cmd_code == CODE_OFF);
  assign c_syn = cmd_wr && (cmd_code == CODE_SYN);
  assign c_rx  = cmd_wr && (cmd_code == CODE_RX);

  assign tmr_run   = (st_q == S_REGW) || (st_q == S_PLLW) ||
                     ((st_q == S_LISTEN) && !locked_q);
  assign tmr_limit = (st_q == S_REGW) ? settle_cycles : lock_cycles;

  rtrx_wait_timer #(.CNT_W(CNT_W)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .start   (tmr_start),
    .run     (tmr_run),
    .limit   (tmr_limit),
    .expired (tmo)
  );

  always_comb begin
    st_d      = st_q;
    locked_d  = locked_q;
    crc_d     = crc_q;
    ev        = '0;
    tmr_start = 1'b0;
    case (st_q)
      S_PON: begin
        if (c_off) begin
          st_d = S_OFF;
          ev[IRQ_AWAKE] = 1'b1;
        end
      end
      S_OFF: begin
        if (c_syn) begin
          st_d = S_REGW;
          tmr_start = 1'b1;
        end
      end
      S_REGW: begin
        if (c_off) begin
          st_d = S_OFF;
        end else if (reg_ready) begin
          st_d = S_PLLW;
          tmr_start = 1'b1;
        end else if (tmo) begin
          st_d = S_OFF;
          ev[IRQ_TMO] = 1'b1;
        end
      end
      S_PLLW: begin
        if (c_off) begin
          st_d = S_OFF;
        end else begin
          if (pll_locked) begin
            locked_d = 1'b1;
            ev[IRQ_LOCK] = 1'b1;
          end
          if (c_rx) begin
            st_d = S_LISTEN;
          end else if (pll_locked) begin
            st_d = S_PLLON;
          end else if (tmo) begin
            st_d = S_OFF;
            ev[IRQ_TMO] = 1'b1;
          end
        end
      end
      S_PLLON: begin
        if (c_off)     st_d = S_OFF;
        else if (c_rx) st_d = S_LISTEN;
      end
      S_LISTEN: begin
        if (c_off) begin
          st_d = S_OFF;
        end else if (c_syn) begin
          st_d = locked_q ? S_PLLON : S_PLLW;
        end else if (!locked_q) begin
          if (pll_locked) begin
            locked_d = 1'b1;
            ev[IRQ_LOCK] = 1'b1;
          end else if (tmo) begin
            st_d = S_OFF;
            ev[IRQ_TMO] = 1'b1;
          end
        end else if (shr_seen) begin
          st_d = S_BUSY;
        end
      end
      S_BUSY: begin
        if (phr_valid) ev[IRQ_RXSTA] = 1'b1;
        if (frame_end) begin
          st_d = S_LISTEN;
          ev[IRQ_END] = 1'b1;
          crc_d = fcs_ok;
        end
      end
      default: st_d = S_PON;
    endcase
    if (st_d == S_OFF) locked_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= S_PON;
      locked_q <= 1'b0;
      crc_q    <= 1'b0;
      vreg_q   <= 1'b0;
      synth_q  <= 1'b0;
      rx_q     <= 1'b0;
      frx_q    <= 1'b0;
      code_q   <= CODE_PON;
    end else begin
      st_q     <= st_d;
      locked_q <= locked_d;
      crc_q    <= crc_d;
      vreg_q   <= (st_d == S_REGW) || (st_d == S_PLLW) || (st_d == S_PLLON) ||
                  (st_d == S_LISTEN) || (st_d == S_BUSY);
      synth_q  <= (st_d == S_PLLW) || (st_d == S_PLLON) ||
                  (st_d == S_LISTEN) || (st_d == S_BUSY);
      rx_q     <= (st_d == S_LISTEN) || (st_d == S_BUSY);
      frx_q    <= ((st_d == S_LISTEN) || (st_d == S_BUSY)) && locked_d;
      code_q   <= code_of(st_d);
    end
  end

  rtrx_irq_bank #(.N(IRQ_N)) u_irq (
    .clk    (clk),
    .rst    (rst),
    .set_ev (ev),
    .rd_clr (irq_rd),
    .mask   (irq_mask),
    .flags  (irq_flags),
    .irq    (irq)
  );

  assign vreg_en     = vreg_q;
  assign synth_en    = synth_q;
  assign rx_en       = rx_q;
  assign frame_rx_en = frx_q;
  assign status_code = code_q;
  assign crc_valid   = crc_q;

  // receiver only with synthesizer and regulator running
  p_rx_needs_synth_r5: assert property (@(posedge clk) disable iff (rst)
    rx_en |-> (synth_en && vreg_en));
  // reception gate implies receiver on
  p_frame_gate_r5: assert property (@(posedge clk) disable iff (rst)
    frame_rx_en |-> rx_en);
  // synthesizer comes up only out of the regulator wait with ready seen
  p_synth_after_reg_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(synth_en) |-> ($past(st_q) == S_REGW && $past(reg_ready)));
  // busy is entered only from locked listen on a sync header
  p_busy_entry_r6: assert property (@(posedge clk) disable iff (rst)
    (st_q == S_BUSY && $past(st_q) != S_BUSY) |->
      ($past(st_q) == S_LISTEN && $past(shr_seen) && $past(locked_q)));
  // listen exits to a non-receive state only on a command or timeout
  p_listen_exit_r9: assert property (@(posedge clk) disable iff (rst)
    ($past(st_q) == S_LISTEN && st_q != S_LISTEN && st_q != S_BUSY) |->
      ($past(cmd_wr) || $past(tmo)));
  // frame check status moves only at end of frame
  p_crc_update_r8: assert property (@(posedge clk) disable iff (rst)
    (crc_q != $past(crc_q)) |-> ($past(st_q) == S_BUSY && $past(frame_end)));
endmodule

// File: tb/rtrx_ctrl_tb.sv
module rtrx_ctrl_tb_top;
  localparam int CNT_W  = 16;
  localparam int SETTLE = 6;
  localparam int LOCK   = 9;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_wr = 1'b0;
  logic [4:0] cmd_code = '0;
  logic [CNT_W-1:0] settle_cycles = CNT_W'(SETTLE);
  logic [CNT_W-1:0] lock_cycles = CNT_W'(LOCK);
  logic reg_ready = 0, pll_locked = 0, shr_seen = 0, phr_valid = 0;
  logic frame_end = 0, fcs_ok = 0, irq_rd = 0;
  logic [4:0] irq_mask = 5'h1F;
  logic vreg_en, synth_en, rx_en, frame_rx_en, crc_valid, irq;
  logic [4:0] status_code, irq_flags;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  rtrx_ctrl #(.CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .cmd_code(cmd_code),
    .settle_cycles(settle_cycles), .lock_cycles(lock_cycles),
    .reg_ready(reg_ready), .pll_locked(pll_locked), .shr_seen(shr_seen),
    .phr_valid(phr_valid), .frame_end(frame_end), .fcs_ok(fcs_ok),
    .irq_rd(irq_rd), .irq_mask(irq_mask), .vreg_en(vreg_en),
    .synth_en(synth_en), .rx_en(rx_en), .frame_rx_en(frame_rx_en),
    .status_code(status_code), .crc_valid(crc_valid),
    .irq_flags(irq_flags), .irq(irq)
  );

  // expected enables {vreg, synth, rx} from a status code
  function automatic logic [2:0] exp_en(logic [4:0] code, logic after_reg);
    case (code)
      5'h09, 5'h06, 5'h01: return (code == 5'h09) ? 3'b110 : 3'b111;
      5'h1F: return after_reg ? 3'b110 : 3'b100;
      default: return 3'b000;
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic cmd(logic [4:0] c);
    cmd_wr = 1'b1; cmd_code = c;
    cyc();
    cmd_wr = 1'b0; cmd_code = '0;
  endtask

  task automatic pulse_rd();
    irq_rd = 1'b1; cyc(); irq_rd = 1'b0;
  endtask

  task automatic chk_state(string req, logic [4:0] code, logic after_reg);
    chk(req, status_code, code);
    chk(req, {vreg_en, synth_en, rx_en}, exp_en(code, after_reg));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd20240611));
    repeat (3) cyc();
    // R1 reset values
    chk_state("R1", 5'h00, 1'b0);
    chk("R1 flags", {irq_flags, irq, crc_valid, frame_rx_en}, 0);
    rst = 1'b0;
    cyc();
    chk_state("R1", 5'h00, 1'b0);

    // R2 only off command works in power-on
    cmd(5'h09); cyc();
    chk_state("R2 ignored", 5'h00, 1'b0);
    cmd(5'h06);
    chk("R2 ignored", irq_flags, 0);
    cmd(5'h08);
    chk_state("R2", 5'h08, 1'b0);
    chk("R2 awake", irq_flags, 5'b01000);
    chk("R11 irq", irq, 1);
    pulse_rd();
    chk("R11 clear", {irq_flags, irq}, 0);

    // R3 regulator first
    cmd(5'h09);
    chk_state("R3", 5'h1F, 1'b0);
    cyc(); cyc();
    chk("R3 synth waits", synth_en, 0);
    reg_ready = 1'b1; cyc(); reg_ready = 1'b0;
    chk_state("R3 synth on", 5'h1F, 1'b1);

    // R5 receive before lock
    cmd(5'h06);
    chk_state("R5", 5'h06, 1'b0);
    chk("R5 gate", frame_rx_en, 0);
    shr_seen = 1'b1; cyc(); shr_seen = 1'b0;
    chk("R5 shr ignored", status_code, 5'h06);

    // R4 lock in listen
    pll_locked = 1'b1; cyc();
    chk("R4 lock flag", irq_flags[0], 1);
    chk("R4 gate", frame_rx_en, 1);
    chk("R4 status", status_code, 5'h06);
    pulse_rd();

    // R6 R7 R8 frame
    shr_seen = 1'b1; cyc(); shr_seen = 1'b0;
    chk_state("R6 busy", 5'h01, 1'b1);
    phr_valid = 1'b1; cyc(); phr_valid = 1'b0;
    chk("R7 rx start", irq_flags, 5'b00010);
    chk("R7 status", status_code, 5'h01);
    cmd(5'h08);
    chk("R9 busy ignores cmd", status_code, 5'h01);
    // R11 event in read cycle and masking
    irq_mask = 5'b11011;
    frame_end = 1'b1; fcs_ok = 1'b1; irq_rd = 1'b1; cyc();
    frame_end = 1'b0; fcs_ok = 1'b0; irq_rd = 1'b0;
    chk("R8 back to listen", status_code, 5'h06);
    chk("R8 crc", crc_valid, 1);
    chk("R11 event wins", irq_flags, 5'b00100);
    chk("R11 irq", irq, 0);
    irq_mask = 5'h1F; cyc();
    chk("R11 irq unmasked", irq, 1);
    pulse_rd();
    shr_seen = 1'b1; cyc(); shr_seen = 1'b0;
    frame_end = 1'b1; cyc(); frame_end = 1'b0;
    chk("R8 crc bad", crc_valid, 0);

    // R9 leaving listen
    cmd(5'h09);
    chk_state("R9 synth", 5'h09, 1'b1);
    cmd(5'h06);
    chk("R9 back rx", status_code, 5'h06);
    cmd(5'h08); pll_locked = 1'b0;
    chk_state("R9 off", 5'h08, 1'b0);
    chk("R9 gate", frame_rx_en, 0);
    pulse_rd();

    // R10 regulator timeout
    cmd(5'h09);
    repeat (SETTLE) cyc();
    chk("R10 still waiting", status_code, 5'h1F);
    cyc();
    chk_state("R10 reg timeout", 5'h08, 1'b0);
    chk("R10 flag", irq_flags[4], 1);
    pulse_rd();
    // R10 lock timeout
    cmd(5'h09);
    reg_ready = 1'b1; cyc(); reg_ready = 1'b0;
    repeat (LOCK) cyc();
    chk("R10 still locking", synth_en, 1);
    cyc();
    chk_state("R10 lock timeout", 5'h08, 1'b0);
    chk("R10 flag", irq_flags, 5'b10000);
    pulse_rd();

    // random sessions
    for (int it = 0; it < 30; it++) begin
      int d, l, nf;
      bit early;
      d = int'($urandom_range(SETTLE - 1));
      l = int'($urandom_range(LOCK - 3));
      early = 1'($urandom_range(1));
      nf = int'($urandom_range(3, 1));
      cmd(5'h09);
      repeat (d) cyc();
      chk("R3 rand wait", status_code, 5'h1F);
      reg_ready = 1'b1; cyc(); reg_ready = 1'b0;
      chk_state("R3 rand", 5'h1F, 1'b1);
      if (early) begin
        cmd(5'h06);
        chk("R5 rand", {rx_en, frame_rx_en}, 2'b10);
      end
      repeat (l) cyc();
      pll_locked = 1'b1; cyc();
      chk("R4 rand lock", irq_flags[0], 1);
      if (!early) begin
        chk("R4 rand status", status_code, 5'h09);
        cmd(5'h06);
      end
      chk("R4 rand gate", {status_code, frame_rx_en}, {5'h06, 1'b1});
      for (int f = 0; f < nf; f++) begin
        bit c, p;
        c = 1'($urandom_range(1));
        p = 1'($urandom_range(1));
        shr_seen = 1'b1; cyc(); shr_seen = 1'b0;
        chk("R6 rand", status_code, 5'h01);
        if (p) begin
          phr_valid = 1'b1; cyc(); phr_valid = 1'b0;
          chk("R7 rand", irq_flags[1], 1);
        end
        repeat ($urandom_range(4)) cyc();
        frame_end = 1'b1; fcs_ok = c; cyc();
        frame_end = 1'b0; fcs_ok = 1'b0;
        chk("R8 rand", {status_code, crc_valid, irq_flags[2]}, {5'h06, c, 1'b1});
      end
      cmd(5'h08); pll_locked = 1'b0;
      chk_state("R9 rand", 5'h08, 1'b0);
      pulse_rd();
      chk("R11 rand", irq_flags, 0);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule